// File: doc/BRIEF.md
# Prioritized UART interrupt identifier

This block folds the five interrupt sources of one serial channel into a single request line and an 8-bit identification value. The sources, from highest to lowest priority, are receiver line errors, character timeout, received data at the trigger level, transmit holding register empty, and modem status change. Software reads the identification value to learn which source to service first.

The source conditions come from neighbouring logic as one-cycle event pulses, except received-data-at-trigger, which is a level. The block latches each event, masks it with the 4-bit enable register, and applies the clear-on-access side effects of register reads and writes, which it receives as one-cycle strobes. The FIFO-enable control bit is mirrored into the top two bits of the value. The interrupt output has a separate drive enable, which is set either by the interrupt-output-enable control bit or by a select input that forces it on at all times.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, and whenever nothing is pending and enabled, ident_o[5:0] is 6'b000001 and irq_o is 0.
- R2: A line error event sets a latched flag that takes effect the next cycle. With ier_i[2]=1 it reports code 6'b000110, above every other source. An lsr_rd_i strobe clears it.
- R3: While rx_trig_lvl_i is 1 and ier_i[0]=1, the code is 6'b000100 in the same cycle, unless a higher source is pending. When the level drops, the code leaves this value without any access.
- R4: A character timeout event sets a latched flag. With ier_i[0]=1 it reports code 6'b001100, and it takes precedence over received data. An rbr_rd_i strobe clears it.
- R5: A transmit-empty event sets a latched flag. With ier_i[1]=1 it reports code 6'b000010. It is cleared by a thr_wr_i strobe, or by an isr_rd_i strobe in a cycle where ident_o[5:0] reads 6'b000010. An isr_rd_i while another code is shown leaves it set.
- R6: A modem change event sets a latched flag. With ier_i[3]=1 it reports code 6'b000000. An msr_rd_i strobe clears it.
- R7: The enable bits are ier_i[0] for received data and timeout, ier_i[1] for transmit empty, ier_i[2] for line status and ier_i[3] for modem status. A disabled source is not reported, but its latched flag is kept and shows as soon as the bit is set.
- R8: ident_o[7] and ident_o[6] both equal fifo_en_i.
- R9: irq_o is 1 exactly when ident_o[0] is 0. irq_oe_o equals out_en_i OR force_en_i.
- R10: When an event and its clearing access arrive in the same cycle, the event wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| lsr_err_evt_i | input | 1 | Pulse: overrun, parity, framing or break detected |
| rx_trig_lvl_i | input | 1 | Level: receive data at or above trigger |
| rx_tmo_evt_i | input | 1 | Pulse: character timeout |
| thr_empty_evt_i | input | 1 | Pulse: transmit holding register became empty |
| modem_chg_evt_i | input | 1 | Pulse: modem input changed |
| ier_i | input | 4 | Interrupt enable bits |
| fifo_en_i | input | 1 | FIFO enable control bit |
| out_en_i | input | 1 | Interrupt output enable control bit |
| force_en_i | input | 1 | Select: interrupt output always driven |
| lsr_rd_i | input | 1 | Strobe: line status register read |
| rbr_rd_i | input | 1 | Strobe: receive buffer read |
| isr_rd_i | input | 1 | Strobe: identification register read |
| thr_wr_i | input | 1 | Strobe: transmit holding register write |
| msr_rd_i | input | 1 | Strobe: modem status register read |
| ident_o | output | 8 | Identification register value |
| irq_o | output | 1 | Interrupt request value |
| irq_oe_o | output | 1 | Drive enable for the interrupt pin |

## Verification
The main sweep runs every subset of the five sources against all sixteen enable patterns and both FIFO-enable values. This covers every priority pair and every masking case, and separates a wrong enable-bit mapping from a wrong priority order. Directed sequences then issue the identification read while the transmit-empty code is shown and while a higher code hides it, which separates a conditional clear from an unconditional one. Further sequences collide an event with its own clearing access, drop the received-data level without any access, and walk the output-enable and force inputs.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int CODE_W = 6;
    localparam int IER_W  = 4;
    localparam int NFLAG  = 4;

    // latched flag indices
    localparam int F_LSR = 0;
    localparam int F_TMO = 1;
    localparam int F_THR = 2;
    localparam int F_MSR = 3;

    // enable bit positions
    localparam int E_RXD = 0;
    localparam int E_THR = 1;
    localparam int E_LSR = 2;
    localparam int E_MSR = 3;

    localparam logic [CODE_W-1:0] CODE_NONE = 6'b000001;
    localparam logic [CODE_W-1:0] CODE_LSR  = 6'b000110;
    localparam logic [CODE_W-1:0] CODE_RXD  = 6'b000100;
    localparam logic [CODE_W-1:0] CODE_TMO  = 6'b001100;
    localparam logic [CODE_W-1:0] CODE_THR  = 6'b000010;
    localparam logic [CODE_W-1:0] CODE_MSR  = 6'b000000;

    typedef struct packed {
        logic flag;
    } flag_state_t;
endpackage

// File: rtl/irq_flag.sv
module irq_flag
    import uart_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flag = 1'b0;
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R10: a set in the same cycle as a clear leaves the flag set
    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        set_i |=> flag_o);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  logic [NFLAG-1:0]  flags_i,
    input  logic              rx_lvl_i,
    input  logic [IER_W-1:0]  ier_i,
    output logic [CODE_W-1:0] code_o,
    output logic              any_o
);
    always_comb begin
        code_o = CODE_NONE;
        any_o  = 1'b1;
        if (flags_i[F_LSR] && ier_i[E_LSR])      code_o = CODE_LSR;
        else if (flags_i[F_TMO] && ier_i[E_RXD]) code_o = CODE_TMO;
        else if (rx_lvl_i && ier_i[E_RXD])       code_o = CODE_RXD;
        else if (flags_i[F_THR] && ier_i[E_THR]) code_o = CODE_THR;
        else if (flags_i[F_MSR] && ier_i[E_MSR]) code_o = CODE_MSR;
        else                                     any_o  = 1'b0;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             lsr_err_evt_i,
    input  logic             rx_trig_lvl_i,
    input  logic             rx_tmo_evt_i,
    input  logic             thr_empty_evt_i,
    input  logic             modem_chg_evt_i,
    input  logic [IER_W-1:0] ier_i,
    input  logic             fifo_en_i,
    input  logic             out_en_i,
    input  logic             force_en_i,
    input  logic             lsr_rd_i,
    input  logic             rbr_rd_i,
    input  logic             isr_rd_i,
    input  logic             thr_wr_i,
    input  logic             msr_rd_i,
    output logic [7:0]       ident_o,
    output logic             irq_o,
    output logic             irq_oe_o
);
    logic [NFLAG-1:0]  set_v, clr_v, flags;
    logic [CODE_W-1:0] code;
    logic              any;

    always_comb begin
        set_v        = '0;
        clr_v        = '0;
        set_v[F_LSR] = lsr_err_evt_i;
        set_v[F_TMO] = rx_tmo_evt_i;
        set_v[F_THR] = thr_empty_evt_i;
        set_v[F_MSR] = modem_chg_evt_i;
        clr_v[F_LSR] = lsr_rd_i;
        clr_v[F_TMO] = rbr_rd_i;
        clr_v[F_THR] = thr_wr_i || (isr_rd_i && code == CODE_THR);
        clr_v[F_MSR] = msr_rd_i;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        irq_flag u_flag (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .set_i  (set_v[i]),
            .clr_i  (clr_v[i]),
            .flag_o (flags[i])
        );
    end

    irq_prio_enc u_enc (
        .flags_i  (flags),
        .rx_lvl_i (rx_trig_lvl_i),
        .ier_i    (ier_i),
        .code_o   (code),
        .any_o    (any)
    );

    assign ident_o  = {fifo_en_i, fifo_en_i, code};
    assign irq_o    = any;
    assign irq_oe_o = out_en_i | force_en_i;

    assert_lsr_clear_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (lsr_rd_i && !lsr_err_evt_i) |=> ident_o[5:0] != CODE_LSR);
    assert_lsr_report_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (lsr_err_evt_i && ier_i[E_LSR]) |=> (!ier_i[E_LSR] || ident_o[5:0] == CODE_LSR));
    assert_tmo_clear_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (rbr_rd_i && !rx_tmo_evt_i) |=> ident_o[5:0] != CODE_TMO);
    assert_thr_clear_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (thr_wr_i && !thr_empty_evt_i) |=> ident_o[5:0] != CODE_THR);
    assert_msr_clear_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (msr_rd_i && !modem_chg_evt_i) |=> ident_o[5:0] != CODE_MSR);
    assert_reset_idle_R1: assert property (@(posedge clk_i)
        rst_i |=> (ident_o[5:0] == CODE_NONE || rx_trig_lvl_i));
endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lsr_evt = 0, rx_lvl = 0, tmo_evt = 0, thr_evt = 0, msr_evt = 0;
    logic [3:0] ier = 0;
    logic fe = 0, oen = 0, frc = 0;
    logic lsr_rd = 0, rbr_rd = 0, isr_rd = 0, thr_wr = 0, msr_rd = 0;
    logic [7:0] ident;
    logic irq, irq_oe;
    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    uart_irq_ident dut (
        .clk_i(clk), .rst_i(rst), .lsr_err_evt_i(lsr_evt), .rx_trig_lvl_i(rx_lvl),
        .rx_tmo_evt_i(tmo_evt), .thr_empty_evt_i(thr_evt), .modem_chg_evt_i(msr_evt),
        .ier_i(ier), .fifo_en_i(fe), .out_en_i(oen), .force_en_i(frc),
        .lsr_rd_i(lsr_rd), .rbr_rd_i(rbr_rd), .isr_rd_i(isr_rd), .thr_wr_i(thr_wr),
        .msr_rd_i(msr_rd), .ident_o(ident), .irq_o(irq), .irq_oe_o(irq_oe)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // src bits: 0 line, 1 timeout, 2 rx level, 3 thr, 4 modem
    function automatic logic [5:0] exp_code(logic [4:0] s, logic [3:0] e);
        if (s[0] && e[2]) return 6'h06;
        if (s[1] && e[0]) return 6'h0C;
        if (s[2] && e[0]) return 6'h04;
        if (s[3] && e[1]) return 6'h02;
        if (s[4] && e[3]) return 6'h00;
        return 6'h01;
    endfunction

    function automatic string tag(logic [5:0] c);
        case (c)
            6'h06: return "R2";
            6'h0C: return "R4";
            6'h04: return "R3";
            6'h02: return "R5";
            6'h00: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic clear_all();
        @(negedge clk);
        lsr_rd = 1; rbr_rd = 1; thr_wr = 1; msr_rd = 1; rx_lvl = 0;
        @(negedge clk);
        lsr_rd = 0; rbr_rd = 0; thr_wr = 0; msr_rd = 0;
    endtask

    task automatic pulse_evts(logic [4:0] s);
        lsr_evt = s[0]; tmo_evt = s[1]; rx_lvl = s[2]; thr_evt = s[3]; msr_evt = s[4];
        @(negedge clk);
        lsr_evt = 0; tmo_evt = 0; thr_evt = 0; msr_evt = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ident", ident, 8'h01);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);
        rst = 0;
        @(negedge clk);
        chk("R1 idle ident", ident, 8'h01);

        // exhaustive sweep: sources x enables x fifo enable
        for (int f = 0; f < 2; f++) begin
            for (int e = 0; e < 16; e++) begin
                for (int s = 0; s < 32; s++) begin
                    logic [5:0] c;
                    clear_all();
                    ier = 4'(e); fe = 1'(f);
                    pulse_evts(5'(s));
                    c = exp_code(5'(s), 4'(e));
                    chk(tag(c), ident, {fe, fe, c});
                    chk("R9 irq", {7'd0, irq}, {7'd0, (c != 6'h01)});
                end
            end
        end
        chk("R8 mirror", {6'd0, ident[7:6]}, 8'h03);

        // R3: level is seen in the same cycle and drops without access
        clear_all(); fe = 0; ier = 4'hF;
        @(negedge clk); rx_lvl = 1; #1;
        chk("R3 level same cycle", ident, 8'h04);
        rx_lvl = 0; #1;
        chk("R3 level dropped", ident, 8'h01);

        // R5: isr read while thr code shown clears it
        clear_all(); ier = 4'h2;
        pulse_evts(5'b01000);
        chk("R5 thr set", ident, 8'h02);
        isr_rd = 1; @(negedge clk); isr_rd = 0;
        chk("R5 isr read clears", ident, 8'h01);

        // R5: isr read while line code shown keeps thr
        ier = 4'h6;
        pulse_evts(5'b01001);
        chk("R2 line above thr", ident, 8'h06);
        isr_rd = 1; @(negedge clk); isr_rd = 0;
        chk("R5 isr read under line", ident, 8'h06);
        lsr_rd = 1; @(negedge clk); lsr_rd = 0;
        chk("R5 thr kept", ident, 8'h02);
        thr_wr = 1; @(negedge clk); thr_wr = 0;
        chk("R5 thr write clears", ident, 8'h01);

        // R10: event collides with its clear
        thr_evt = 1; thr_wr = 1; @(negedge clk); thr_evt = 0; thr_wr = 0;
        chk("R10 thr set wins", ident, 8'h02);
        ier = 4'h8;
        msr_evt = 1; msr_rd = 1; @(negedge clk); msr_evt = 0; msr_rd = 0;
        chk("R10 msr set wins", ident, 8'h00);
        msr_rd = 1; @(negedge clk); msr_rd = 0;
        chk("R6 msr read clears", ident, 8'h01);

        // R7: latched while disabled, shows when enabled
        clear_all(); ier = 4'h0;
        pulse_evts(5'b10000);
        chk("R7 masked", ident, 8'h01);
        ier = 4'h8; #1;
        chk("R7 unmasked", ident, 8'h00);
        ier = 4'h1;
        tmo_evt = 1; @(negedge clk); tmo_evt = 0;
        chk("R4 timeout", ident, 8'h0C);
        rbr_rd = 1; @(negedge clk); rbr_rd = 0;
        chk("R4 rbr read clears", ident, 8'h01);

        // R9: output enable
        for (int k = 0; k < 4; k++) begin
            oen = k[0]; frc = k[1]; #1;
            chk("R9 oe", {7'd0, irq_oe}, {7'd0, (k != 0)});
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule